// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger Control

This block provides the two character buffers that sit between a UART's shift logic and its host: one holds bytes waiting to be sent, the other holds bytes that have arrived. Each is 32 bytes deep. A host writes an 8-bit control byte and four auxiliary level bytes over a small write-only register bus. The control byte switches the buffers between deep mode and single-byte holding mode, clears either buffer with bits that do not stay set, and picks a trigger code for each direction.

Two level-sensitive interrupt outputs result. The receive-ready interrupt asserts once the receive fill reaches its threshold. The transmit-empty interrupt asserts while the transmit fill is below its threshold. The thresholds normally come from the trigger codes. If any of the four auxiliary bytes is nonzero, the receive-level and transmit-level bytes set the thresholds instead. The UART core is represented by push and pop strobes on each buffer.

Top module: `uart_fifo_pair`

## Requirements
- R1: After synchronous reset, deep mode is off, both fills are 0, both overrun flags are 0, both pop data outputs are 0, the receive-ready interrupt is 0 and the transmit-empty interrupt is 1.
- R2: Control byte (register address 0) bit 0 selects deep mode: capacity is 32 bytes per buffer when 1 and 1 byte when 0. `fifo_on` reflects the stored bit from the cycle after the write.
- R3: Writing address 0 with bit 1 set empties the receive buffer and clears its overrun flag at that clock edge. The bit is not stored, so a later write with bit 1 clear leaves the receive buffer untouched.
- R4: Writing address 0 with bit 2 set empties the transmit buffer and clears its overrun flag at that clock edge. The bit is not stored.
- R5: Control bit 3 has no effect on any output.
- R6: Control bits 7:6 select the receive threshold: code 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 28 bytes. `rx_ready_irq` is 1 exactly when the receive fill is at or above the threshold.
- R7: Control bits 5:4 select the transmit threshold with the same code-to-byte mapping. `tx_empty_irq` is 1 exactly when the transmit fill is below the threshold.
- R8: The auxiliary bytes sit at address 1 (receive level), 2 (transmit level), 3 (flow low) and 4 (flow high). Addresses 5 to 7 are ignored. In deep mode, if any of the four bytes is nonzero, the receive and transmit thresholds equal the bytes at addresses 1 and 2.
- R9: When deep mode is off, both thresholds are 1 byte, whatever the codes and auxiliary bytes hold.
- R10: A push to a buffer at capacity, with no accepted pop in the same cycle, is dropped and sets that buffer's sticky overrun flag. A pop in the same cycle frees the space, so the push is accepted.
- R11: An accepted pop puts the oldest byte on the pop data output after the clock edge, in first-in first-out order. A pop from an empty buffer leaves both the data output and the fill unchanged. A push in the same cycle does not satisfy that pop.
- R12: A control write that changes bit 0 empties both buffers and clears both overrun flags at that edge. A simultaneous push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1-4 auxiliary levels) |
| reg_wdata | input | 8 | Register write data |
| rx_push | input | 1 | Received byte strobe from the UART core |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host read strobe for the receive buffer |
| rx_pop_data | output | 8 | Last byte read from the receive buffer |
| tx_push | input | 1 | Host write strobe for the transmit buffer |
| tx_push_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | UART core fetch strobe for the transmit buffer |
| tx_pop_data | output | 8 | Last byte fetched from the transmit buffer |
| rx_count | output | 6 | Receive fill (0 to 32) |
| tx_count | output | 6 | Transmit fill (0 to 32) |
| rx_ready_irq | output | 1 | Receive fill at or above threshold |
| tx_empty_irq | output | 1 | Transmit fill below threshold |
| rx_overrun | output | 1 | Sticky flag: a receive push was dropped |
| tx_overrun | output | 1 | Sticky flag: a transmit push was dropped |
| fifo_on | output | 1 | Deep mode active |

## Verification
A wrong pointer or fill register shows up in `rx_count`/`tx_count` on the cycle after the faulty edge. A byte order or empty-read fault appears on the pop data outputs at the next pop. A bad stored trigger code or override decision changes an interrupt level the moment the fill crosses the wrong boundary, so a stimulus that sweeps the fill across every threshold exposes it within one pass. A missed or stuck clear appears as a nonzero fill or a lingering overrun flag one cycle after the control write.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_AW = 3;
    localparam int LVL_W  = 8;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTRL    = 3'd0,
        SEL_RX_LVL  = 3'd1,
        SEL_TX_LVL  = 3'd2,
        SEL_FLOW_LO = 3'd3,
        SEL_FLOW_HI = 3'd4
    } reg_sel_e;

    // stored part of the control byte
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       deep_en;
    } ctrl_state_t;

    typedef struct packed {
        logic [LVL_W-1:0] rx_lvl;
        logic [LVL_W-1:0] tx_lvl;
        logic [LVL_W-1:0] flow_lo;
        logic [LVL_W-1:0] flow_hi;
    } aux_lvl_t;

    function automatic logic [LVL_W-1:0] trig_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(24);
            default: return LVL_W'(28);
        endcase
    endfunction

endpackage

// File: rtl/fifo_ctrl_regs.sv
module fifo_ctrl_regs
    import uart_fifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output ctrl_state_t         ctrl_q,
    output aux_lvl_t            aux_q,
    output logic                rx_clr,
    output logic                tx_clr
);

    logic ctrl_wr;
    logic mode_flip;

    assign ctrl_wr   = we && (reg_sel_e'(addr) == SEL_CTRL);
    assign mode_flip = ctrl_wr && (wdata[0] != ctrl_q.deep_en);
    assign rx_clr    = (ctrl_wr && wdata[1]) || mode_flip;
    assign tx_clr    = (ctrl_wr && wdata[2]) || mode_flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            aux_q  <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                SEL_CTRL: begin
                    ctrl_q.deep_en <= wdata[0];
                    ctrl_q.tx_code <= wdata[5:4];
                    ctrl_q.rx_code <= wdata[7:6];
                end
                SEL_RX_LVL:  aux_q.rx_lvl  <= wdata;
                SEL_TX_LVL:  aux_q.tx_lvl  <= wdata;
                SEL_FLOW_LO: aux_q.flow_lo <= wdata;
                SEL_FLOW_HI: aux_q.flow_hi <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fifo_buf.sv
module fifo_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] count,
    output logic          overrun
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          at_cap, do_pop, do_push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign at_cap  = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!at_cap || do_pop);

    always_ff @(posedge clk) begin
        if (!rst && !clr && do_push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            pop_data <= '0;
        end else if (clr) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop) begin
                rd_ptr   <= bump(rd_ptr);
                pop_data <= mem[rd_ptr];
            end
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && !do_push) overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/trig_eval.sv
module trig_eval
    import uart_fifo_pkg::*;
#(
    parameter int CW = 6
) (
    input  ctrl_state_t   ctrl,
    input  aux_lvl_t      aux,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_irq,
    output logic          tx_irq
);

    logic             aux_any;
    logic [LVL_W-1:0] rx_thr, tx_thr;

    assign aux_any = |aux;

    always_comb begin
        if (!ctrl.deep_en) begin
            rx_thr = LVL_W'(1);
            tx_thr = LVL_W'(1);
        end else if (aux_any) begin
            rx_thr = aux.rx_lvl;
            tx_thr = aux.tx_lvl;
        end else begin
            rx_thr = trig_bytes(ctrl.rx_code);
            tx_thr = trig_bytes(ctrl.tx_code);
        end
    end

    assign rx_irq = LVL_W'(rx_count) >= rx_thr;
    assign tx_irq = LVL_W'(tx_count) <  tx_thr;

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_pop_data,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_pop_data,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count,
    output logic              rx_ready_irq,
    output logic              tx_empty_irq,
    output logic              rx_overrun,
    output logic              tx_overrun,
    output logic              fifo_on
);

    ctrl_state_t ctrl_q;
    aux_lvl_t    aux_q;
    logic        rx_clr, tx_clr;

    fifo_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q),
        .aux_q  (aux_q),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    fifo_buf #(.W(BYTE_W), .DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clr),
        .single    (!ctrl_q.deep_en),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .overrun   (rx_overrun)
    );

    fifo_buf #(.W(BYTE_W), .DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_clr),
        .single    (!ctrl_q.deep_en),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .overrun   (tx_overrun)
    );

    trig_eval #(.CW(CW)) u_trig (
        .ctrl     (ctrl_q),
        .aux      (aux_q),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_irq   (rx_ready_irq),
        .tx_irq   (tx_empty_irq)
    );

    assign fifo_on = ctrl_q.deep_en;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [7:0]    rx_pop_data,
    input logic          tx_push,
    input logic          tx_pop,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_overrun,
    input logic          tx_overrun,
    input logic          fifo_on
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == 3'd0);

    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH))); // R2

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1))); // R9

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[1]) |=> (rx_count == '0) && !rx_overrun); // R3

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[2]) |=> (tx_count == '0) && !tx_overrun); // R4

    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !rx_pop && !reg_we &&
         rx_count == (fifo_on ? CW'(DEPTH) : CW'(1)))
        |=> rx_overrun && $stable(rx_count)); // R10

    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_pop && !reg_we &&
         tx_count == (fifo_on ? CW'(DEPTH) : CW'(1)))
        |=> tx_overrun && $stable(tx_count)); // R10

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_push && !reg_we && rx_count == '0)
        |=> $stable(rx_pop_data) && (rx_count == '0)); // R11

    AST_MODE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (fifo_on != $past(fifo_on)) |-> (rx_count == '0) && (tx_count == '0)); // R12

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_pop_data (rx_pop_data),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .rx_overrun  (rx_overrun),
    .tx_overrun  (tx_overrun),
    .fifo_on     (fifo_on)
);

// File: tb/uart_fifo_pair_tb_top.sv
module uart_fifo_pair_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       rx_push, rx_pop, tx_push, tx_pop;
    logic [7:0] rx_push_data, tx_push_data;
    logic [7:0] rx_pop_data, tx_pop_data;
    logic [5:0] rx_count, tx_count;
    logic       rx_ready_irq, tx_empty_irq, rx_overrun, tx_overrun, fifo_on;

    always #5 clk = ~clk;

    uart_fifo_pair dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .tx_push(tx_push),
        .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .rx_count(rx_count), .tx_count(tx_count), .rx_ready_irq(rx_ready_irq),
        .tx_empty_irq(tx_empty_irq), .rx_overrun(rx_overrun),
        .tx_overrun(tx_overrun), .fifo_on(fifo_on)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit            m_en;
    bit [1:0]      m_rxc, m_txc;
    bit [7:0]      m_aux [4];
    byte unsigned  rxq[$], txq[$];
    bit [7:0]      m_rxd, m_txd;
    bit            m_rxo, m_txo;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl(input bit [1:0] c);
        case (c)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 24;
            default: return 28;
        endcase
    endfunction

    function automatic bit aux_any();
        return (m_aux[0] | m_aux[1] | m_aux[2] | m_aux[3]) != 8'd0;
    endfunction

    function automatic int rx_thr();
        if (!m_en) return 1;
        if (aux_any()) return int'(m_aux[0]);
        return lvl(m_rxc);
    endfunction

    function automatic int tx_thr();
        if (!m_en) return 1;
        if (aux_any()) return int'(m_aux[1]);
        return lvl(m_txc);
    endfunction

    task automatic q_step(ref byte unsigned q[$], ref bit [7:0] last, ref bit ovr,
                          input bit clr, input bit push, input bit pop,
                          input bit [7:0] d, input int cap);
        bit popped;
        if (clr) begin
            q.delete();
            ovr = 0;
            return;
        end
        popped = 0;
        if (pop && q.size() > 0) begin
            last = q.pop_front();
            popped = 1;
        end
        if (push) begin
            if (q.size() < cap || popped) q.push_back(d);
            else ovr = 1;
        end
    endtask

    task automatic model_edge();
        bit cw, flip, crx, ctx;
        int cap;
        cw   = reg_we && reg_addr == 3'd0;
        flip = cw && (reg_wdata[0] != m_en);
        crx  = (cw && reg_wdata[1]) || flip;
        ctx  = (cw && reg_wdata[2]) || flip;
        cap  = m_en ? 32 : 1;
        q_step(rxq, m_rxd, m_rxo, crx, rx_push, rx_pop, rx_push_data, cap);
        q_step(txq, m_txd, m_txo, ctx, tx_push, tx_pop, tx_push_data, cap);
        if (reg_we) begin
            case (reg_addr)
                3'd0: begin m_en = reg_wdata[0]; m_txc = reg_wdata[5:4]; m_rxc = reg_wdata[7:6]; end
                3'd1: m_aux[0] = reg_wdata;
                3'd2: m_aux[1] = reg_wdata;
                3'd3: m_aux[2] = reg_wdata;
                3'd4: m_aux[3] = reg_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        chk("R2", "rx_count", int'(rx_count), rxq.size());
        chk("R2", "tx_count", int'(tx_count), txq.size());
        chk("R2", "fifo_on", int'(fifo_on), int'(m_en));
        chk("R6", "rx_ready_irq", int'(rx_ready_irq), int'(rxq.size() >= rx_thr()));
        chk("R7", "tx_empty_irq", int'(tx_empty_irq), int'(txq.size() < tx_thr()));
        chk("R10", "rx_overrun", int'(rx_overrun), int'(m_rxo));
        chk("R10", "tx_overrun", int'(tx_overrun), int'(m_txo));
        chk("R11", "rx_pop_data", int'(rx_pop_data), int'(m_rxd));
        chk("R11", "tx_pop_data", int'(tx_pop_data), int'(m_txd));
    endtask

    task automatic idle();
        reg_we = 0; reg_addr = '0; reg_wdata = '0;
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        rx_push_data = '0; tx_push_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        compare_all();
        idle();
    endtask

    task automatic wr_reg(input bit [2:0] a, input bit [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rx_put(input bit [7:0] d);
        rx_push = 1; rx_push_data = d; tick();
    endtask

    task automatic tx_put(input bit [7:0] d);
        tx_push = 1; tx_push_data = d; tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        m_en = 0; m_rxc = 0; m_txc = 0; m_rxd = 0; m_txd = 0; m_rxo = 0; m_txo = 0;
        foreach (m_aux[i]) m_aux[i] = 0;

        // R1 reset state
        chk("R1", "fifo_on", int'(fifo_on), 0);
        chk("R1", "rx_count", int'(rx_count), 0);
        chk("R1", "tx_count", int'(tx_count), 0);
        chk("R1", "rx_ready_irq", int'(rx_ready_irq), 0);
        chk("R1", "tx_empty_irq", int'(tx_empty_irq), 1);
        chk("R1", "overruns", int'({rx_overrun, tx_overrun}), 0);
        chk("R1", "pop_data", int'({rx_pop_data, tx_pop_data}), 0);

        // R9 holding mode: one byte, threshold 1
        rx_put(8'hA1);
        chk("R9", "rx_ready_irq single", int'(rx_ready_irq), 1);
        rx_put(8'hA2);
        chk("R9", "rx_count single", int'(rx_count), 1);
        chk("R10", "rx_overrun single", int'(rx_overrun), 1);
        tx_put(8'h11);
        chk("R9", "tx_empty_irq single", int'(tx_empty_irq), 0);

        // R12 enable flips: both emptied, flags cleared
        wr_reg(3'd0, 8'h01);
        chk("R12", "rx_count after enable", int'(rx_count), 0);
        chk("R12", "tx_count after enable", int'(tx_count), 0);
        chk("R12", "rx_overrun after enable", int'(rx_overrun), 0);

        // R10 fill to 32 then overflow
        for (int i = 0; i < 33; i++) rx_put(8'(i + 8'h40));
        chk("R10", "rx_count full", int'(rx_count), 32);
        chk("R10", "rx_overrun full", int'(rx_overrun), 1);

        // R11 drain in order, then pop empty
        for (int i = 0; i < 32; i++) begin
            rx_pop = 1; tick();
            chk("R11", "rx order", int'(rx_pop_data), i + 8'h40);
        end
        rx_pop = 1; tick();
        chk("R11", "empty pop data", int'(rx_pop_data), 8'h5F);
        chk("R11", "empty pop count", int'(rx_count), 0);

        // R3 receive clear, self-clearing bit
        rx_put(8'h01); rx_put(8'h02);
        wr_reg(3'd0, 8'h03);
        chk("R3", "rx cleared", int'(rx_count), 0);
        chk("R3", "rx overrun cleared", int'(rx_overrun), 0);
        rx_put(8'h03);
        wr_reg(3'd0, 8'h01);
        chk("R3", "no stored clear", int'(rx_count), 1);

        // R7 transmit code 1 -> 16
        wr_reg(3'd0, 8'h11);
        for (int i = 0; i < 15; i++) tx_put(8'(i));
        chk("R7", "tx below 16", int'(tx_empty_irq), 1);
        tx_put(8'hFF);
        chk("R7", "tx at 16", int'(tx_empty_irq), 0);

        // R4 transmit clear
        rx_put(8'h04);
        wr_reg(3'd0, 8'h15);
        chk("R4", "tx cleared", int'(tx_count), 0);
        chk("R4", "rx kept", int'(rx_count), 2);

        // R6 receive code 3 -> 28
        wr_reg(3'd0, 8'hC1);
        for (int i = 0; i < 25; i++) rx_put(8'(i));
        chk("R6", "rx 27 below 28", int'(rx_ready_irq), 0);
        rx_put(8'h77);
        chk("R6", "rx 28 at 28", int'(rx_ready_irq), 1);

        // R5 reserved bit has no effect
        wr_reg(3'd0, 8'hC9);
        chk("R5", "rx_count kept", int'(rx_count), 28);
        chk("R5", "rx irq kept", int'(rx_ready_irq), 1);
        chk("R5", "tx irq kept", int'(tx_empty_irq), 1);

        // R8 override by flow-high only: thresholds 0/0
        wr_reg(3'd0, 8'h03);
        wr_reg(3'd4, 8'h05);
        chk("R8", "rx irq thr 0", int'(rx_ready_irq), 1);
        chk("R8", "tx irq thr 0", int'(tx_empty_irq), 0);
        wr_reg(3'd1, 8'd3);
        rx_put(8'h01); rx_put(8'h02);
        chk("R8", "rx 2 below 3", int'(rx_ready_irq), 0);
        rx_put(8'h03);
        chk("R8", "rx 3 at 3", int'(rx_ready_irq), 1);
        wr_reg(3'd5, 8'hFF);
        chk("R8", "address 5 ignored", int'(rx_ready_irq), 1);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd1, 8'h00);
        chk("R8", "codes back, 3 below 8", int'(rx_ready_irq), 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            rx_push = ($urandom % 3) != 0;
            rx_push_data = 8'($urandom);
            rx_pop = ($urandom % 2) != 0;
            tx_push = ($urandom % 2) != 0;
            tx_push_data = 8'($urandom);
            tx_pop = ($urandom % 3) != 0;
            if (($urandom % 40) == 0) begin
                reg_we = 1;
                reg_addr = 3'($urandom % 6);
                if (reg_addr == 3'd0) begin
                    reg_wdata = 8'($urandom);
                    reg_wdata[0] = ($urandom % 8) != 0;
                    if (($urandom % 2) == 0) reg_wdata[2:1] = 2'b00;
                end else begin
                    reg_wdata = (($urandom % 4) == 0) ? 8'($urandom % 34) : 8'h00;
                end
            end
            tick();
        end

        summary();
        $finish;
    end

endmodule